// File: doc/BRIEF.md
# Dual-Lane Serial Sample Output Sequencer

This block reproduces the digital side of a two-channel converter that samples both channels at the same instant and hands the results out over two serial lines. Two 12-bit words, standing in for the conversion results, are presented in parallel. While the active-low select is high, the block keeps copying them in. When select falls, the block freezes both words, raises a hold flag and switches both serial lines on. Each falling edge of the serial clock then moves both lines one bit further through a 16-bit frame. The frame is two zeros, then the 12 data bits with the most significant bit first, then two zeros.

Lane A can carry the second channel's frame straight after its own. To do this, the host keeps select low and clocks on to 32 falling edges. Lane B carries only its own frame. Each lane is modelled as a data bit plus an output enable, and a disabled lane drives 0 on its data bit.

Select and the serial clock are levels that are oversampled by the block clock. Their edges are found inside the block, and every output moves on the block clock edge at which an edge is detected.

Top module: `adcser_dual_out`

## Requirements
- R1: On a detected falling edge of `cs_n`, both enables go high, `hold` goes high, and both data bits are 0. This 0 is the first leading zero, present before any serial clock edge.
- R2: Let k be the count of `sclk` falling edges since select fell. For k=1 both lanes show 0. For k=2..13 lane A shows bit (13-k) of channel A's word and lane B shows bit (13-k) of channel B's word, so the most significant bit comes first.
- R3: For k=14 and k=15 both lanes show 0 and both enables stay high.
- R4: From k=16 onward, `oe_b` is low and `sdata_b` is 0, and `oe_b` is never high while `oe_a` is low.
- R5: While select stays low, lane A carries channel B's frame for k=16..31. It shows 0 at k=16 and 17, bit (29-k) of channel B's word for k=18..29, and 0 at k=30 and 31.
- R6: At k=32 `oe_a` goes low, and further `sclk` falling edges with select still low leave both lanes disabled.
- R7: A detected rising edge of `cs_n` at any k disables both lanes and clears `hold` on that block clock edge. The next select fall starts again at k=0.
- R8: `hold` stays high through the 13th `sclk` falling edge. It goes low on the first `sclk` rising edge after that falling edge.
- R9: The words are captured only while `cs_n` is high. A word change made while select is low does not affect the running frame.
- R10: A disabled lane drives 0, including when `sclk` toggles while select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples select and serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; its fall starts a frame and its rise ends it |
| sclk | input | 1 | Serial clock level; each falling edge advances the frame |
| smp_a | input | 12 | Channel A sample word |
| smp_b | input | 12 | Channel B sample word |
| sdata_a | output | 1 | Lane A serial data bit |
| oe_a | output | 1 | Lane A drive enable (low means three-state) |
| sdata_b | output | 1 | Lane B serial data bit |
| oe_b | output | 1 | Lane B drive enable (low means three-state) |
| hold | output | 1 | High while the sample is held, low while tracking |

## Verification
Short 16-clock frames use words with asymmetric bit patterns, such as 0xA5C against 0x3F0, so that a reversed bit order, a swapped channel or a one-position shift each shows up as a mismatched bit. An all-ones word against an all-zeros word separates the data bits from the framing zeros, and a wrong preamble or trailer length then gives an obvious mismatch. A 34-clock frame with distinct end-bit patterns (0x801, 0x7FE) checks the chaining on lane A, the early shut-off of lane B and the point at which lane A goes quiet. Aborted frames and word changes made while select is low check that a frame can be cut short and that the captured words stay frozen.

// File: rtl/adcser_pkg.sv
package adcser_pkg;
    localparam int DEF_DATA_W  = 12;
    localparam int DEF_LEAD_Z  = 2;
    localparam int DEF_TRAIL_Z = 2;
    localparam int NUM_LANES   = 2;
    localparam int LANE_A      = 0;
    localparam int LANE_B      = 1;
endpackage

// File: rtl/adcser_edge.sv
module adcser_edge #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
        rise   = din & ~prev_q;
        fall   = ~din & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/adcser_slot.sv
module adcser_slot #(
    parameter int DATA_W = 12,
    parameter int LEAD_Z = 2,
    parameter int CNT_W  = 6
) (
    input  logic [CNT_W-1:0]  pos,
    input  logic [DATA_W-1:0] word,
    output logic              bit_out
);
    localparam logic [CNT_W-1:0] FIRST_POS = CNT_W'(LEAD_Z);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(LEAD_Z + DATA_W - 1);

    logic [CNT_W-1:0]  idx;
    logic [DATA_W-1:0] shifted;
    logic              in_data;

    always_comb begin
        in_data = (pos >= FIRST_POS) && (pos <= LAST_POS);
        idx     = LAST_POS - pos;
        shifted = word >> idx;
        bit_out = in_data & shifted[0];
    end
endmodule

// File: rtl/adcser_dual_out.sv
module adcser_dual_out
    import adcser_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int LEAD_Z  = DEF_LEAD_Z,
    parameter int TRAIL_Z = DEF_TRAIL_Z
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] smp_a,
    input  logic [DATA_W-1:0] smp_b,
    output logic              sdata_a,
    output logic              oe_a,
    output logic              sdata_b,
    output logic              oe_b,
    output logic              hold
);
    localparam int FRAME_LEN = LEAD_Z + DATA_W + TRAIL_Z;
    localparam int CHAIN_LEN = 2 * FRAME_LEN;
    localparam int CNT_W     = $clog2(CHAIN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(CHAIN_LEN);
    localparam logic [CNT_W-1:0] FRAME_CNT  = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] TRACK_CNT  = CNT_W'(LEAD_Z + DATA_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic              hold;
        logic [DATA_W-1:0] word_a;
        logic [DATA_W-1:0] word_b;
    } seq_t;

    seq_t st_d, st_q;

    logic cs_rise, cs_fall, sck_rise, sck_fall;

    adcser_edge #(.IDLE_LVL(1'b1)) u_cs_edge (
        .clk (clk), .rst_n (rst_n), .din (cs_n),
        .rise(cs_rise), .fall(cs_fall)
    );

    adcser_edge #(.IDLE_LVL(1'b1)) u_sck_edge (
        .clk (clk), .rst_n (rst_n), .din (sclk),
        .rise(sck_rise), .fall(sck_fall)
    );

    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d.word_a = smp_a;
            st_d.word_b = smp_b;
        end
        if (cs_rise) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.hold   = 1'b0;
        end else if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.hold   = 1'b1;
        end else if (st_q.active) begin
            if (sck_fall && (st_q.cnt != CNT_MAX))
                st_d.cnt = st_q.cnt + 1'b1;
            if (sck_rise && (st_q.cnt >= TRACK_CNT))
                st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [CNT_W-1:0]  lane_pos  [NUM_LANES];
    logic [DATA_W-1:0] lane_word [NUM_LANES];
    logic              lane_en   [NUM_LANES];
    logic              lane_bit  [NUM_LANES];

    always_comb begin
        if (st_q.cnt >= FRAME_CNT) begin
            lane_pos[LANE_A]  = st_q.cnt - FRAME_CNT;
            lane_word[LANE_A] = st_q.word_b;
        end else begin
            lane_pos[LANE_A]  = st_q.cnt;
            lane_word[LANE_A] = st_q.word_a;
        end
        lane_en[LANE_A]   = st_q.active && (st_q.cnt < CNT_MAX);
        lane_pos[LANE_B]  = st_q.cnt;
        lane_word[LANE_B] = st_q.word_b;
        lane_en[LANE_B]   = st_q.active && (st_q.cnt < FRAME_CNT);
    end

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        adcser_slot #(.DATA_W(DATA_W), .LEAD_Z(LEAD_Z), .CNT_W(CNT_W)) u_slot (
            .pos    (lane_pos[ln]),
            .word   (lane_word[ln]),
            .bit_out(lane_bit[ln])
        );
    end

    assign oe_a    = lane_en[LANE_A];
    assign oe_b    = lane_en[LANE_B];
    assign sdata_a = lane_en[LANE_A] & lane_bit[LANE_A];
    assign sdata_b = lane_en[LANE_B] & lane_bit[LANE_B];
    assign hold    = st_q.hold;
endmodule

// File: rtl/adcser_dual_out_chk.sv
module adcser_dual_out_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdata_a,
    input logic oe_a,
    input logic sdata_b,
    input logic oe_b,
    input logic hold
);
    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> (oe_a && oe_b && hold && !sdata_a && !sdata_b)); // R1

    AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> (!oe_a && !oe_b && !hold)); // R7

    AST_B_INSIDE_A: assert property (@(posedge clk) disable iff (!rst_n)
        oe_b |-> oe_a); // R4

    AST_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_a |-> !sdata_a); // R10

    AST_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_b |-> !sdata_b); // R10

    AST_NO_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !oe_a) |=> !oe_a); // R6
endmodule

bind adcser_dual_out adcser_dual_out_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .sdata_a(sdata_a), .oe_a(oe_a), .sdata_b(sdata_b), .oe_b(oe_b), .hold(hold)
);

// File: tb/adcser_dual_out_tb.sv
module adcser_dual_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] smp_a = '0;
    logic [11:0] smp_b = '0;
    logic        sdata_a, oe_a, sdata_b, oe_b, hold;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adcser_dual_out u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .smp_a(smp_a), .smp_b(smp_b),
        .sdata_a(sdata_a), .oe_a(oe_a), .sdata_b(sdata_b), .oe_b(oe_b), .hold(hold)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic frame_bit(int pos, logic [11:0] w);
        if (pos >= 2 && pos <= 13) return w[13 - pos];
        return 1'b0;
    endfunction

    function automatic string tag_for(int k);
        if (k <= 13) return "R2";
        if (k <= 15) return "R3";
        if (k <= 31) return "R5";
        return "R6";
    endfunction

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_down();
        sclk = 1'b0;
        wait_n(2);
    endtask

    task automatic sck_up();
        sclk = 1'b1;
        wait_n(2);
    endtask

    task automatic open_frame(logic [11:0] a, logic [11:0] b);
        smp_a = a;
        smp_b = b;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(2);
        chk("R1", "oe_a at select fall", int'(oe_a), 1);
        chk("R1", "oe_b at select fall", int'(oe_b), 1);
        chk("R1", "hold at select fall", int'(hold), 1);
        chk("R1", "sdata_a first zero", int'(sdata_a), 0);
        chk("R1", "sdata_b first zero", int'(sdata_b), 0);
    endtask

    task automatic close_frame();
        cs_n = 1'b1;
        wait_n(2);
        chk("R7", "oe_a after select rise", int'(oe_a), 0);
        chk("R7", "oe_b after select rise", int'(oe_b), 0);
        chk("R7", "hold after select rise", int'(hold), 0);
        chk("R10", "sdata_a idle", int'(sdata_a), 0);
        chk("R10", "sdata_b idle", int'(sdata_b), 0);
    endtask

    task automatic clock_frame(logic [11:0] a, logic [11:0] b, int nclk);
        for (int k = 1; k <= nclk; k++) begin
            logic ea, eb, ena, enb;
            sck_down();
            ena = (k < 32);
            enb = (k < 16);
            ea  = ena ? ((k < 16) ? frame_bit(k, a) : frame_bit(k - 16, b)) : 1'b0;
            eb  = enb ? frame_bit(k, b) : 1'b0;
            chk(tag_for(k), $sformatf("oe_a k=%0d", k), int'(oe_a), int'(ena));
            chk(tag_for(k), $sformatf("sdata_a k=%0d", k), int'(sdata_a), int'(ea));
            chk((k >= 16) ? "R4" : tag_for(k), $sformatf("oe_b k=%0d", k), int'(oe_b), int'(enb));
            chk((k >= 16) ? "R4" : tag_for(k), $sformatf("sdata_b k=%0d", k), int'(sdata_b), int'(eb));
            chk("R8", $sformatf("hold after fall k=%0d", k), int'(hold), (k >= 14) ? 0 : 1);
            sck_up();
            chk("R8", $sformatf("hold after rise k=%0d", k), int'(hold), (k >= 13) ? 0 : 1);
        end
    endtask

    task automatic t_reset();
        chk("R10", "reset oe_a", int'(oe_a), 0);
        chk("R10", "reset oe_b", int'(oe_b), 0);
        chk("R10", "reset sdata_a", int'(sdata_a), 0);
        chk("R10", "reset sdata_b", int'(sdata_b), 0);
        chk("R8", "reset hold", int'(hold), 0);
    endtask

    task automatic t_short(logic [11:0] a, logic [11:0] b);
        open_frame(a, b);
        clock_frame(a, b, 16);
        close_frame();
    endtask

    task automatic t_chain(logic [11:0] a, logic [11:0] b);
        open_frame(a, b);
        clock_frame(a, b, 34);
        close_frame();
    endtask

    task automatic t_abort();
        open_frame(12'hFFF, 12'hFFF);
        clock_frame(12'hFFF, 12'hFFF, 6);
        chk("R2", "sdata_a mid-frame one", int'(sdata_a), 1);
        close_frame();
        for (int i = 0; i < 3; i++) begin
            sck_down();
            chk("R10", "sdata_a with select high", int'(sdata_a), 0);
            chk("R10", "oe_b with select high", int'(oe_b), 0);
            sck_up();
        end
        open_frame(12'hC3A, 12'h35C);
        clock_frame(12'hC3A, 12'h35C, 16);
        close_frame();
    endtask

    task automatic t_ignore();
        open_frame(12'h9A6, 12'h1E7);
        smp_a = 12'h000;
        smp_b = 12'hFFF;
        wait_n(2);
        chk("R9", "sdata_a after word change", int'(sdata_a), 0);
        clock_frame(12'h9A6, 12'h1E7, 16);
        close_frame();
        open_frame(12'h000, 12'hFFF);
        clock_frame(12'h000, 12'hFFF, 14);
        close_frame();
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_short(12'hA5C, 12'h3F0);
        t_short(12'hFFF, 12'h000);
        t_chain(12'h801, 12'h7FE);
        t_chain(12'h123, 12'hC96);
        t_abort();
        t_ignore();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule